// File: doc/BRIEF.md
# Calendar and Alarm Mode Controller

This block is the menu logic of a date-keeping display. Four debounced buttons enter it as single-clock pulses: calendar select, alarm select, increment and decrement. It keeps two coupled state registers. The calendar register picks what the main display shows: the running date, the running weekday, or one edit state for each date field. The alarm register picks idle, a view of the stored alarm date, or one edit state for each alarm field.

The two registers lock each other out. The alarm menu cannot be entered while the calendar is away from its idle state. A calendar-select press made inside the alarm menu drops both registers straight back to the running date view. Increment and decrement pulses are routed only to the field that is being edited, as one-cycle strobes toward the calendar counters or toward the alarm store. A run-enable output tells the day counter when it may advance, and it holds the counter during any edit.

Calendar states, in press order: RUN_DATE(0) → RUN_WDAY(1) → ED_Y3(2) → ED_Y2(3) → ED_Y1(4) → ED_Y0(5) → ED_MON(6) → ED_DAY(7) → RUN_DATE. Alarm states: IDLE(0) → VIEW(1) → ED_Y3(2) → ED_Y2(3) → ED_Y1(4) → ED_Y0(5) → ED_MON(6) → ED_DAY(7) → VIEW. The transition "abort" takes the alarm from any non-idle state to IDLE and the calendar to RUN_DATE.

Top module: `cal_alarm_mode_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets cal_mode and alm_mode to 0. After reset edit_field is 0, all four strobes are low and date_run is high.
- R2: While alm_mode is 0, each cycle with cal_sel_p high moves cal_mode one step through 0,1,2,...,7, and from 7 it returns to 0.
- R3: While cal_mode is not 0, alm_sel_p has no effect, so alm_mode stays 0.
- R4: With cal_mode at 0, alm_sel_p moves alm_mode from 0 to 1, then one step per pulse through 2..7. From 7 it goes to 1, and never to 0.
- R5: A cal_sel_p pulse while alm_mode is not 0 sets both alm_mode and cal_mode to 0 on the next cycle.
- R6: When cal_sel_p and alm_sel_p are high in the same cycle, only the calendar-select action takes place and the alarm-select pulse is discarded.
- R7: cal_inc and cal_dec copy inc_p and dec_p in the same cycle only while cal_mode is 2..7. alm_inc and alm_dec do the same only while alm_mode is 2..7. In every other state all four strobes are low.
- R8: edit_field encodes the field under edit: 0 none, 1 year thousands, 2 year hundreds, 3 year tens, 4 year units, 5 month, 6 day. It equals cal_mode-1 when cal_mode is 2..7, equals alm_mode-1 when alm_mode is 2..7, and is 0 otherwise.
- R9: date_run is high exactly when both modes are 0 or cal_mode is 1.
- R10: A cycle with neither select pulse leaves both modes unchanged, and increment and decrement pulses never change a mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_sel_p | input | 1 | Calendar-select pulse, one cycle per press |
| alm_sel_p | input | 1 | Alarm-select pulse, one cycle per press |
| inc_p | input | 1 | Increment pulse |
| dec_p | input | 1 | Decrement pulse |
| cal_mode | output | 3 | Calendar state code 0..7 |
| alm_mode | output | 3 | Alarm state code 0..7 |
| edit_field | output | 3 | Field under edit (R8 encoding) |
| cal_inc | output | 1 | Increment strobe to the calendar field |
| cal_dec | output | 1 | Decrement strobe to the calendar field |
| alm_inc | output | 1 | Increment strobe to the alarm field |
| alm_dec | output | 1 | Decrement strobe to the alarm field |
| date_run | output | 1 | Day counter may advance |

## Verification
Two pairs of functions can land in one cycle. The first pair is the two select keys. The bench raises cal_sel_p and alm_sel_p together from the idle state, and again from inside the alarm edit states. It expects the calendar step or the abort alone, with the alarm pulse discarded. The second pair is a select press and an adjust pulse. The bench gives inc_p and dec_p together with a select press on the cycle that leaves an edit state. It expects the strobe to follow the state held before the edge, and the new state to gate only the following cycles.

// File: rtl/cmc_pkg.sv
`timescale 1ns/1ps
package cmc_pkg;
    parameter int MODE_W  = 3;
    parameter int FIELD_W = 3;

    typedef enum logic [MODE_W-1:0] {
        CAL_RUN_DATE = 3'd0,
        CAL_RUN_WDAY = 3'd1,
        CAL_ED_Y3    = 3'd2,
        CAL_ED_Y2    = 3'd3,
        CAL_ED_Y1    = 3'd4,
        CAL_ED_Y0    = 3'd5,
        CAL_ED_MON   = 3'd6,
        CAL_ED_DAY   = 3'd7
    } cal_st_e;

    typedef enum logic [MODE_W-1:0] {
        ALM_IDLE   = 3'd0,
        ALM_VIEW   = 3'd1,
        ALM_ED_Y3  = 3'd2,
        ALM_ED_Y2  = 3'd3,
        ALM_ED_Y1  = 3'd4,
        ALM_ED_Y0  = 3'd5,
        ALM_ED_MON = 3'd6,
        ALM_ED_DAY = 3'd7
    } alm_st_e;

    typedef enum logic [FIELD_W-1:0] {
        FLD_NONE = 3'd0,
        FLD_Y3   = 3'd1,
        FLD_Y2   = 3'd2,
        FLD_Y1   = 3'd3,
        FLD_Y0   = 3'd4,
        FLD_MON  = 3'd5,
        FLD_DAY  = 3'd6
    } field_e;
endpackage

// File: rtl/cmc_cal_fsm.sv
`timescale 1ns/1ps
module cmc_cal_fsm
    import cmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cal_sel_p,
    input  logic    alm_busy,
    output cal_st_e state,
    output field_e  field,
    output logic    editing,
    output logic    idle
);
    cal_st_e st_q, st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= CAL_RUN_DATE;
        else     st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        if (cal_sel_p) begin
            if (alm_busy) begin
                st_nx = CAL_RUN_DATE;          // abort out of the alarm menu
            end else begin
                unique case (st_q)
                    CAL_RUN_DATE: st_nx = CAL_RUN_WDAY;
                    CAL_RUN_WDAY: st_nx = CAL_ED_Y3;
                    CAL_ED_Y3:    st_nx = CAL_ED_Y2;
                    CAL_ED_Y2:    st_nx = CAL_ED_Y1;
                    CAL_ED_Y1:    st_nx = CAL_ED_Y0;
                    CAL_ED_Y0:    st_nx = CAL_ED_MON;
                    CAL_ED_MON:   st_nx = CAL_ED_DAY;
                    CAL_ED_DAY:   st_nx = CAL_RUN_DATE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        field   = FLD_NONE;
        editing = 1'b0;
        idle    = 1'b0;
        unique case (st_q)
            CAL_RUN_DATE: idle = 1'b1;
            CAL_RUN_WDAY: ;
            CAL_ED_Y3:    begin field = FLD_Y3;  editing = 1'b1; end
            CAL_ED_Y2:    begin field = FLD_Y2;  editing = 1'b1; end
            CAL_ED_Y1:    begin field = FLD_Y1;  editing = 1'b1; end
            CAL_ED_Y0:    begin field = FLD_Y0;  editing = 1'b1; end
            CAL_ED_MON:   begin field = FLD_MON; editing = 1'b1; end
            CAL_ED_DAY:   begin field = FLD_DAY; editing = 1'b1; end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/cmc_alm_fsm.sv
`timescale 1ns/1ps
module cmc_alm_fsm
    import cmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alm_sel_p,
    input  logic    cal_sel_p,
    input  logic    cal_idle,
    output alm_st_e state,
    output field_e  field,
    output logic    editing,
    output logic    busy
);
    alm_st_e st_q, st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ALM_IDLE;
        else     st_q <= st_nx;
    end

    // next state: calendar key has priority and aborts the menu
    always_comb begin
        st_nx = st_q;
        if (cal_sel_p) begin
            st_nx = ALM_IDLE;
        end else if (alm_sel_p && cal_idle) begin
            unique case (st_q)
                ALM_IDLE:   st_nx = ALM_VIEW;
                ALM_VIEW:   st_nx = ALM_ED_Y3;
                ALM_ED_Y3:  st_nx = ALM_ED_Y2;
                ALM_ED_Y2:  st_nx = ALM_ED_Y1;
                ALM_ED_Y1:  st_nx = ALM_ED_Y0;
                ALM_ED_Y0:  st_nx = ALM_ED_MON;
                ALM_ED_MON: st_nx = ALM_ED_DAY;
                ALM_ED_DAY: st_nx = ALM_VIEW;
            endcase
        end
    end

    // outputs
    always_comb begin
        field   = FLD_NONE;
        editing = 1'b0;
        busy    = 1'b1;
        unique case (st_q)
            ALM_IDLE:   busy = 1'b0;
            ALM_VIEW:   ;
            ALM_ED_Y3:  begin field = FLD_Y3;  editing = 1'b1; end
            ALM_ED_Y2:  begin field = FLD_Y2;  editing = 1'b1; end
            ALM_ED_Y1:  begin field = FLD_Y1;  editing = 1'b1; end
            ALM_ED_Y0:  begin field = FLD_Y0;  editing = 1'b1; end
            ALM_ED_MON: begin field = FLD_MON; editing = 1'b1; end
            ALM_ED_DAY: begin field = FLD_DAY; editing = 1'b1; end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/cmc_strobe_route.sv
`timescale 1ns/1ps
module cmc_strobe_route
    import cmc_pkg::*;
(
    input  logic   inc_p,
    input  logic   dec_p,
    input  logic   cal_editing,
    input  logic   alm_editing,
    input  field_e cal_field,
    input  field_e alm_field,
    output logic   cal_inc,
    output logic   cal_dec,
    output logic   alm_inc,
    output logic   alm_dec,
    output field_e edit_field
);
    always_comb begin
        cal_inc    = 1'b0;
        cal_dec    = 1'b0;
        alm_inc    = 1'b0;
        alm_dec    = 1'b0;
        edit_field = FLD_NONE;
        if (cal_editing) begin
            cal_inc    = inc_p;
            cal_dec    = dec_p;
            edit_field = cal_field;
        end else if (alm_editing) begin
            alm_inc    = inc_p;
            alm_dec    = dec_p;
            edit_field = alm_field;
        end
    end
endmodule

// File: rtl/cal_alarm_mode_ctrl.sv
`timescale 1ns/1ps
module cal_alarm_mode_ctrl
    import cmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cal_sel_p,
    input  logic               alm_sel_p,
    input  logic               inc_p,
    input  logic               dec_p,
    output logic [MODE_W-1:0]  cal_mode,
    output logic [MODE_W-1:0]  alm_mode,
    output logic [FIELD_W-1:0] edit_field,
    output logic               cal_inc,
    output logic               cal_dec,
    output logic               alm_inc,
    output logic               alm_dec,
    output logic               date_run
);
    cal_st_e cal_st;
    alm_st_e alm_st;
    field_e  cal_fld, alm_fld, fld_out;
    logic    cal_edit, cal_idle, alm_edit, alm_busy;

    cmc_cal_fsm u_cal (
        .clk       (clk),
        .rst       (rst),
        .cal_sel_p (cal_sel_p),
        .alm_busy  (alm_busy),
        .state     (cal_st),
        .field     (cal_fld),
        .editing   (cal_edit),
        .idle      (cal_idle)
    );

    cmc_alm_fsm u_alm (
        .clk       (clk),
        .rst       (rst),
        .alm_sel_p (alm_sel_p),
        .cal_sel_p (cal_sel_p),
        .cal_idle  (cal_idle),
        .state     (alm_st),
        .field     (alm_fld),
        .editing   (alm_edit),
        .busy      (alm_busy)
    );

    cmc_strobe_route u_route (
        .inc_p       (inc_p),
        .dec_p       (dec_p),
        .cal_editing (cal_edit),
        .alm_editing (alm_edit),
        .cal_field   (cal_fld),
        .alm_field   (alm_fld),
        .cal_inc     (cal_inc),
        .cal_dec     (cal_dec),
        .alm_inc     (alm_inc),
        .alm_dec     (alm_dec),
        .edit_field  (fld_out)
    );

    assign cal_mode   = cal_st;
    assign alm_mode   = alm_st;
    assign edit_field = fld_out;
    assign date_run   = (cal_idle && !alm_busy) || (cal_st == CAL_RUN_WDAY);
endmodule

// File: rtl/cal_alarm_mode_ctrl_chk.sv
`timescale 1ns/1ps
module cal_alarm_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cal_sel_p,
    input logic       alm_sel_p,
    input logic       inc_p,
    input logic       dec_p,
    input logic [2:0] cal_mode,
    input logic [2:0] alm_mode,
    input logic [2:0] edit_field,
    input logic       cal_inc,
    input logic       cal_dec,
    input logic       alm_inc,
    input logic       alm_dec,
    input logic       date_run
);
    // R2: calendar wraps from day edit back to running date
    assert_cal_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cal_sel_p && alm_mode == 3'd0 && cal_mode == 3'd7) |=> (cal_mode == 3'd0));

    // R3: the two menus are never both away from idle
    assert_mutex_R3: assert property (@(posedge clk) disable iff (rst)
        (cal_mode != 3'd0) |-> (alm_mode == 3'd0));

    // R3: alarm key ignored while calendar busy
    assert_alm_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (alm_sel_p && !cal_sel_p && cal_mode != 3'd0) |=> (alm_mode == 3'd0));

    // R4: once in the alarm menu, alarm presses never reach idle
    assert_alm_no_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (alm_sel_p && !cal_sel_p && alm_mode != 3'd0) |=> (alm_mode != 3'd0));

    // R5: calendar key inside the alarm menu aborts both
    assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (cal_sel_p && alm_mode != 3'd0) |=> (alm_mode == 3'd0 && cal_mode == 3'd0));

    // R6: simultaneous selects from idle step the calendar only
    assert_cal_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (cal_sel_p && alm_sel_p && alm_mode == 3'd0 && cal_mode == 3'd0)
        |=> (cal_mode == 3'd1 && alm_mode == 3'd0));

    // R7: strobes only toward an editing menu, never toward both
    assert_cal_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (cal_inc || cal_dec) |-> (cal_mode >= 3'd2));
    assert_alm_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (alm_inc || alm_dec) |-> (alm_mode >= 3'd2));
    assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cal_inc | cal_dec, alm_inc | alm_dec}));

    // R8: no field is reported in a view state
    assert_field_view_R8: assert property (@(posedge clk) disable iff (rst)
        (cal_mode < 3'd2 && alm_mode < 3'd2) |-> (edit_field == 3'd0));

    // R9: day counter held during any edit or alarm menu
    assert_run_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (alm_mode != 3'd0 || cal_mode >= 3'd2) |-> !date_run);

    // R10: no select pulse, no mode change
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!cal_sel_p && !alm_sel_p) |=> ($stable(cal_mode) && $stable(alm_mode)));
endmodule

bind cal_alarm_mode_ctrl cal_alarm_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cal_sel_p  (cal_sel_p),
    .alm_sel_p  (alm_sel_p),
    .inc_p      (inc_p),
    .dec_p      (dec_p),
    .cal_mode   (cal_mode),
    .alm_mode   (alm_mode),
    .edit_field (edit_field),
    .cal_inc    (cal_inc),
    .cal_dec    (cal_dec),
    .alm_inc    (alm_inc),
    .alm_dec    (alm_dec),
    .date_run   (date_run)
);

// File: tb/cal_alarm_mode_ctrl_tb.sv
`timescale 1ns/1ps
module cal_alarm_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cal_sel_p, alm_sel_p, inc_p, dec_p;
    logic [2:0] cal_mode, alm_mode, edit_field;
    logic       cal_inc, cal_dec, alm_inc, alm_dec, date_run;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cal = 0;
    int m_alm = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cal_alarm_mode_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .cal_sel_p  (cal_sel_p),
        .alm_sel_p  (alm_sel_p),
        .inc_p      (inc_p),
        .dec_p      (dec_p),
        .cal_mode   (cal_mode),
        .alm_mode   (alm_mode),
        .edit_field (edit_field),
        .cal_inc    (cal_inc),
        .cal_dec    (cal_dec),
        .alm_inc    (alm_inc),
        .alm_dec    (alm_dec),
        .date_run   (date_run)
    );

    task automatic cmp(input string req, input string sig, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d (cal=%0d alm=%0d)",
                     req, sig, act, exp, m_cal, m_alm);
        end
    endtask

    // compare all outputs against the model, then clock one edge
    task automatic vec(input bit c, input bit a, input bit i, input bit d, input string req);
        int e_fld;
        bit c_ed, a_ed, e_run;
        cal_sel_p = c; alm_sel_p = a; inc_p = i; dec_p = d;
        #1;
        c_ed  = (m_cal >= 2);
        a_ed  = (m_alm >= 2);
        e_fld = c_ed ? m_cal - 1 : (a_ed ? m_alm - 1 : 0);
        e_run = (m_cal == 0 && m_alm == 0) || (m_cal == 1);
        vectors++;
        cmp(req, "cal_mode",   int'(cal_mode),   m_cal);
        cmp(req, "alm_mode",   int'(alm_mode),   m_alm);
        cmp(req, "edit_field", int'(edit_field), e_fld);          // R8
        cmp(req, "cal_inc",    int'(cal_inc),    int'(c_ed & i)); // R7
        cmp(req, "cal_dec",    int'(cal_dec),    int'(c_ed & d));
        cmp(req, "alm_inc",    int'(alm_inc),    int'(a_ed & i));
        cmp(req, "alm_dec",    int'(alm_dec),    int'(a_ed & d));
        cmp(req, "date_run",   int'(date_run),   int'(e_run));    // R9
        @(posedge clk);
        if (c) begin
            if (m_alm != 0) begin m_cal = 0; m_alm = 0; end
            else m_cal = (m_cal + 1) % 8;
        end else if (a && m_cal == 0) begin
            m_alm = (m_alm == 7) ? 1 : m_alm + 1;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cal_sel_p = 0; alm_sel_p = 0; inc_p = 0; dec_p = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cal = 0; m_alm = 0;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        vec(0, 0, 0, 0, "R1");
        // R7: adjust pulses in running views reach nothing
        vec(0, 0, 1, 0, "R7");
        vec(0, 0, 0, 1, "R7");

        // R2: walk the calendar menu with adjust pulses in each state (R8, R9)
        for (int k = 0; k < 9; k++) begin
            vec(1, 0, 0, 0, "R2");
            vec(0, 0, 1, 0, "R7");
            vec(0, 0, 0, 1, "R7");
            vec(0, 0, 1, 1, "R8");
            vec(0, 0, 0, 0, "R10");
        end
        // now cal=1; step to 3 and press alarm key: R3
        vec(1, 0, 0, 0, "R2");
        vec(1, 0, 0, 0, "R2");
        vec(0, 1, 0, 0, "R3");
        vec(0, 1, 1, 0, "R3");
        vec(0, 0, 0, 0, "R3");
        // select press together with adjust while leaving an edit state
        vec(1, 0, 1, 1, "R7");
        vec(0, 0, 1, 1, "R7");
        // back to idle
        while (m_cal != 0) vec(1, 0, 0, 0, "R2");
        vec(0, 0, 0, 0, "R9");

        // R6: both keys together from idle
        vec(1, 1, 0, 0, "R6");
        vec(0, 0, 0, 0, "R6");
        while (m_cal != 0) vec(1, 0, 0, 0, "R2");

        // R4: alarm menu, two full cycles
        for (int k = 0; k < 16; k++) begin
            vec(0, 1, 0, 0, "R4");
            vec(0, 0, 1, 0, "R7");
            vec(0, 0, 0, 1, "R7");
            vec(0, 0, 1, 1, "R10");
        end
        // R5: abort from an edit state
        while (m_alm != 4) vec(0, 1, 0, 0, "R4");
        vec(1, 0, 1, 0, "R5");
        vec(0, 0, 1, 0, "R5");
        // R5: abort from alarm view
        vec(0, 1, 0, 0, "R4");
        vec(1, 0, 0, 0, "R5");
        vec(0, 0, 0, 0, "R5");
        // R6: both keys together inside alarm edit
        vec(0, 1, 0, 0, "R4");
        vec(0, 1, 0, 0, "R4");
        vec(0, 1, 0, 0, "R4");
        vec(1, 1, 0, 1, "R6");
        vec(0, 0, 0, 0, "R6");
        // R10: long quiet stretch with adjust traffic only
        vec(0, 1, 0, 0, "R4");
        vec(0, 1, 0, 0, "R4");
        for (int k = 0; k < 6; k++) vec(0, 0, k % 2, (k / 2) % 2, "R10");

        // R1: reset in the middle of an alarm edit
        do_reset();
        vec(0, 0, 1, 1, "R1");
        vec(1, 0, 0, 0, "R2");
        vec(1, 0, 0, 0, "R2");
        do_reset();
        vec(0, 0, 0, 0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule